// File: doc/BRIEF.md
# Dual-Port Address Conflict Arbiter

This block sits beside a memory with two independent ports. It decides which port goes ahead when both are selected at the same address. The losing port sees an active-low busy flag, and its write qualifier is forced low so that the memory array never takes a write from it. The flag stays low until the winning port deselects or moves to another address. At that point the waiting port is let through in the same cycle.

Ordering comes from the history of the two ports, which is kept in registers sampled on the previous clock edge. Suppose the addresses already agreed and the chip selects completed the conflict. Then the port that was selected first wins. Suppose instead that both ports were already selected and an address change created the match. Then the port whose address did not move wins. Any tie goes to the left port.

When several of these memories are put side by side to widen the data bus, only one of them arbitrates. That one runs in master mode. The others run in slave mode: they take the busy flags from the master as inputs and use them only to block writes. Because every device follows one decision, two devices cannot each stall a different side.

Top module: `dpc_arbiter`

## Requirements
- R1: With both ports selected and equal addresses, in master mode, exactly one busy output is low. In every other case both busy outputs are high.
- R2: Suppose the addresses were equal in the previous cycle and the selects complete the conflict. Then the port that was already selected in the previous cycle wins, and the newly selected port's busy goes low in the same cycle.
- R3: Suppose both ports were selected in the previous cycle with unequal addresses and an address change creates the match. Then the port that changed its address loses.
- R4: If both ports become late contenders in the same cycle (both newly selected, or both changed address), the left port wins.
- R5: In master mode, while a port's busy output is low, its write qualifier is low even if it requests a write. The winning port's qualifier equals its select ANDed with its write request.
- R6: Once granted, a winner keeps the grant in every later cycle in which it stays selected at the same address and the conflict remains. This holds even when the ordering rules would now favour the other port.
- R7: When the winner deselects or changes address, the loser's busy returns high and its write qualifier follows its own select and write request, both in that same cycle.
- R8: In master mode the external busy inputs have no effect on any output.
- R9: With the mode input low (slave), both busy outputs stay high whatever the selects and addresses are.
- R10: In slave mode a port's write qualifier is its select AND its write request AND its external busy input (1 = not busy). A low busy input blocks that port's write.
- R11: While reset is asserted and in the first cycle after it, before any conflict, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = follow external busy |
| l_sel | input | 1 | Left port selected (active high) |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| l_busy_in_n | input | 1 | Left busy from the master, active low (slave mode only) |
| r_sel | input | 1 | Right port selected (active high) |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| r_busy_in_n | input | 1 | Right busy from the master, active low (slave mode only) |
| l_busy_n | output | 1 | Left port inhibited, active low |
| r_busy_n | output | 1 | Right port inhibited, active low |
| l_wr_ok | output | 1 | Qualified write enable for the left port |
| r_wr_ok | output | 1 | Qualified write enable for the right port |

## Verification
A corrupted grant register appears at the ports in the very next cycle of a continuing conflict. The busy flag moves to the other side, which breaks R6, or both flags rise during a conflict, which breaks R1. Stale select or address history shows only when a fresh conflict begins, as the wrong side being marked busy under R2 or R3. The directed cases therefore create each ordering from a quiet start and then hold it for several cycles. A qualifier that ignored busy would let the loser's write through in the same cycle that busy is low.

// File: rtl/dpc_arb_pkg.sv
package dpc_arb_pkg;
    localparam int NPORT = 2;
    localparam int P_LEFT = 0;
    localparam int P_RIGHT = 1;

    typedef enum logic [1:0] {
        GR_NONE  = 2'd0,
        GR_LEFT  = 2'd1,
        GR_RIGHT = 2'd2
    } grant_e;
endpackage

// File: rtl/arb_order.sv
// Decides the winner of a freshly arising conflict from last-cycle history.
module arb_order
    import dpc_arb_pkg::*;
(
    input  logic [NPORT-1:0] sel_prev,
    input  logic [NPORT-1:0] addr_moved,
    input  logic             match_prev,
    output logic             left_wins
);
    logic [NPORT-1:0] late;

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_late
            // Address already agreed: decided by selects. Otherwise by addresses.
            assign late[p] = match_prev ? !sel_prev[p]
                                        : (!sel_prev[p] || addr_moved[p]);
        end
    endgenerate

    // Left loses only if it alone arrived late.
    assign left_wins = !(late[P_LEFT] && !late[P_RIGHT]);
endmodule

// File: rtl/arb_port_gate.sv
// Per-port busy output and write qualifier.
module arb_port_gate (
    input  logic master,
    input  logic sel,
    input  logic wr,
    input  logic lost,
    input  logic busy_in_n,
    output logic busy_n,
    output logic wr_ok
);
    logic blocked;

    always_comb begin
        busy_n  = !(master && lost);
        blocked = master ? lost : !busy_in_n;
        wr_ok   = sel && wr && !blocked;
    end
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
    import dpc_arb_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_busy_in_n,
    input  logic              r_sel,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    typedef struct packed {
        grant_e                       grant;
        logic [NPORT-1:0]             sel;
        logic [NPORT-1:0][ADDR_W-1:0] addr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NPORT-1:0]             sel_v;
    logic [NPORT-1:0]             wr_v;
    logic [NPORT-1:0]             bin_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0]             moved;
    logic [NPORT-1:0]             lost;
    logic [NPORT-1:0]             busy_v;
    logic [NPORT-1:0]             wok_v;
    logic                         conflict;
    logic                         match_q;
    logic                         left_wins;
    logic                         keep;

    assign sel_v  = {r_sel, l_sel};
    assign wr_v   = {r_wr, l_wr};
    assign bin_v  = {r_busy_in_n, l_busy_in_n};
    assign addr_v = {r_addr, l_addr};

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_moved
            assign moved[p] = addr_v[p] != st_q.addr[p];
        end
    endgenerate

    assign conflict = sel_v[P_LEFT] && sel_v[P_RIGHT]
                   && (addr_v[P_LEFT] == addr_v[P_RIGHT]);
    assign match_q  = st_q.addr[P_LEFT] == st_q.addr[P_RIGHT];

    arb_order i_order (
        .sel_prev   (st_q.sel),
        .addr_moved (moved),
        .match_prev (match_q),
        .left_wins  (left_wins)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sel   = sel_v;
        st_d.addr  = addr_v;
        st_d.grant = GR_NONE;
        keep = ((st_q.grant == GR_LEFT)  && !moved[P_LEFT])
            || ((st_q.grant == GR_RIGHT) && !moved[P_RIGHT]);
        if (master_mode && conflict) begin
            if (keep) begin
                st_d.grant = st_q.grant;
            end else begin
                st_d.grant = left_wins ? GR_LEFT : GR_RIGHT;
            end
        end
        lost[P_LEFT]  = st_d.grant == GR_RIGHT;
        lost[P_RIGHT] = st_d.grant == GR_LEFT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{grant: GR_NONE, sel: '0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            arb_port_gate i_gate (
                .master    (master_mode),
                .sel       (sel_v[p]),
                .wr        (wr_v[p]),
                .lost      (lost[p]),
                .busy_in_n (bin_v[p]),
                .busy_n    (busy_v[p]),
                .wr_ok     (wok_v[p])
            );
        end
    endgenerate

    assign l_busy_n = busy_v[P_LEFT];
    assign r_busy_n = busy_v[P_RIGHT];
    assign l_wr_ok  = wok_v[P_LEFT];
    assign r_wr_ok  = wok_v[P_RIGHT];
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_sel,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_sel,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_wr,
    input logic              r_wr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_ok,
    input logic              r_wr_ok
);
    logic clash;
    assign clash = l_sel && r_sel && (l_addr == r_addr);

    a_r1_quiet_without_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(master_mode && clash) |-> (l_busy_n && r_busy_n));

    a_r1_one_side_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && clash) |-> $countones({~l_busy_n, ~r_busy_n}) == 1);

    a_r5_left_loser_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n |-> !l_wr_ok);

    a_r5_right_loser_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n |-> !r_wr_ok);

    a_r6_right_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(master_mode) && $past(!l_busy_n) && master_mode && clash
         && $stable(r_addr)) |-> !l_busy_n);

    a_r9_slave_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_n && r_busy_n));

    a_r10_slave_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && (!l_busy_in_n || !l_sel || !l_wr)) |-> !l_wr_ok);
endmodule

bind dpc_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_sel       (l_sel),
    .l_addr      (l_addr),
    .r_sel       (r_sel),
    .r_addr      (r_addr),
    .l_wr        (l_wr),
    .r_wr        (r_wr),
    .l_busy_in_n (l_busy_in_n),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr_ok     (l_wr_ok),
    .r_wr_ok     (r_wr_ok)
);

// File: tb/test_dpc_arbiter.sv
`timescale 1ns/1ps
module test_dpc_arbiter;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          l_sel = 1'b0, r_sel = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_wr = 1'b0, r_wr = 1'b0;
    logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic          l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dpc_arbiter #(.ADDR_W(AW)) i_dpc_arbiter (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_sel(l_sel), .l_addr(l_addr), .l_wr(l_wr), .l_busy_in_n(l_busy_in_n),
        .r_sel(r_sel), .r_addr(r_addr), .r_wr(r_wr), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic outs(input string tag, input logic lb, input logic rb,
                        input logic lw, input logic rw);
        chk({tag, " l_busy_n"}, l_busy_n, lb);
        chk({tag, " r_busy_n"}, r_busy_n, rb);
        chk({tag, " l_wr_ok"}, l_wr_ok, lw);
        chk({tag, " r_wr_ok"}, r_wr_ok, rw);
    endtask

    // Drive on the falling edge, let outputs settle, sample before the rising edge.
    task automatic step(input logic ls, input logic [AW-1:0] la, input logic lw,
                        input logic rs, input logic [AW-1:0] ra, input logic rw);
        @(negedge clk);
        l_sel = ls; l_addr = la; l_wr = lw;
        r_sel = rs; r_addr = ra; r_wr = rw;
        #2;
    endtask

    task automatic quiet();
        step(0, l_addr, 0, 0, r_addr, 0);
        step(0, l_addr, 0, 0, r_addr, 0);
    endtask

    task automatic t_reset();
        #2;
        outs("R11 in reset", 1, 1, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        outs("R11 after reset", 1, 1, 0, 0);
    endtask

    task automatic t_no_clash();
        quiet();
        step(1, 13'h10, 1, 1, 13'h11, 1);
        outs("R1 distinct addr", 1, 1, 1, 1);
        step(1, 13'h10, 1, 0, 13'h10, 1);
        outs("R1 right unselected", 1, 1, 1, 0);
    endtask

    task automatic t_select_order();
        quiet();
        step(1, 13'h1FFE, 1, 0, 13'h1FFE, 0);
        step(1, 13'h1FFE, 1, 1, 13'h1FFE, 1);
        outs("R2 left first", 1, 0, 1, 0);
        quiet();
        step(0, 13'h0020, 0, 1, 13'h0020, 1);
        step(1, 13'h0020, 1, 1, 13'h0020, 1);
        outs("R2 right first", 0, 1, 0, 1);
    endtask

    task automatic t_addr_order();
        quiet();
        step(1, 13'h3, 0, 1, 13'h7, 0);
        step(1, 13'h7, 1, 1, 13'h7, 1);
        outs("R3 left moved", 0, 1, 0, 1);
        quiet();
        step(1, 13'h3, 0, 1, 13'h7, 0);
        step(1, 13'h3, 1, 1, 13'h3, 1);
        outs("R3 right moved", 1, 0, 1, 0);
    endtask

    task automatic t_tie();
        quiet();
        step(1, 13'h44, 1, 1, 13'h44, 1);
        outs("R4 both selected together", 1, 0, 1, 0);
        quiet();
        step(1, 13'h1, 0, 1, 13'h2, 0);
        step(1, 13'h9, 1, 1, 13'h9, 1);
        outs("R4 both moved together", 1, 0, 1, 0);
    endtask

    task automatic t_hold_release();
        quiet();
        step(0, 13'h55, 0, 1, 13'h55, 1);
        step(1, 13'h55, 1, 1, 13'h55, 1);
        outs("R5 right wins", 0, 1, 0, 1);
        for (int i = 0; i < 3; i++) begin
            step(1, 13'h55, 1, 1, 13'h55, (i % 2) == 0);
            outs("R6 grant held", 0, 1, 0, (i % 2) == 0);
        end
        step(1, 13'h55, 1, 0, 13'h55, 0);
        outs("R7 winner deselects", 1, 1, 1, 0);
        quiet();
        step(1, 13'h66, 1, 0, 13'h66, 0);
        step(1, 13'h66, 1, 1, 13'h66, 1);
        outs("R7 setup left wins", 1, 0, 1, 0);
        step(1, 13'h67, 1, 1, 13'h66, 1);
        outs("R7 winner moves", 1, 1, 1, 1);
    endtask

    task automatic t_master_ignores_in();
        quiet();
        l_busy_in_n = 1'b0; r_busy_in_n = 1'b0;
        step(1, 13'h1, 1, 1, 13'h2, 1);
        outs("R8 busy inputs ignored", 1, 1, 1, 1);
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    endtask

    task automatic t_slave();
        quiet();
        master_mode = 1'b0;
        step(1, 13'h30, 1, 1, 13'h30, 1);
        outs("R9 slave no arbitration", 1, 1, 1, 1);
        l_busy_in_n = 1'b0;
        step(1, 13'h30, 1, 1, 13'h30, 1);
        outs("R10 left blocked", 1, 1, 0, 1);
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
        step(1, 13'h30, 1, 1, 13'h30, 1);
        outs("R10 right blocked", 1, 1, 1, 0);
        r_busy_in_n = 1'b1;
        step(1, 13'h30, 0, 1, 13'h30, 1);
        outs("R10 no write request", 1, 1, 0, 1);
        master_mode = 1'b1;
    endtask

    initial begin
        t_reset();
        t_no_clash();
        t_select_order();
        t_addr_order();
        t_tie();
        t_hold_release();
        t_master_ignores_in();
        t_slave();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule